// File: doc/BRIEF.md
# Release-Ordered Write Tracker

This block keeps one processor's memory ordering within release consistency. Every ordinary write that leaves the processor is reported on a write channel. The report carries a tag and the number of invalidation acknowledgements the coherence fabric still owes for that write. A write that owes acknowledgements takes a tracker slot. The slot's count drops by one for each acknowledgement carrying its tag, and the slot is freed when the count reaches zero. A write that owes nothing never takes a slot.

Synchronisation operations come in on a separate request port and are marked as either acquire or release. A release finishes only when every write accepted before it has collected all of its acknowledgements. Writes accepted from the release's own cycle onward do not hold the release up. Ordinary reads and writes are not stalled while a release is pending. An acquire may start while earlier writes are still outstanding. From the acquire's acceptance until memory reports it complete, every later ordinary access is held back. Only one synchronisation operation is in flight at a time, so all four acquire/release pairings stay in program order.

The write channel and the sync channel are valid/ready. A request is taken on a cycle where both valid and ready are high. The source must hold the request and its fields stable until it is taken. Ready may depend on the presented fields: a write that owes no acknowledgements is never refused for lack of a slot. Reads, acknowledgements, acquire completion and the status outputs are plain level signals.

Top module: `rc_write_tracker`

## Requirements
- R1: A write accepted with a nonzero count holds a slot. Each acknowledgement whose tag matches a held slot lowers that slot's count by one. The acknowledgement that takes a count from one to zero frees the slot in that same cycle, so `wr_ready` is high in that cycle even when every slot is held.
- R2: A write with `wr_inv_cnt` equal to zero is accepted without taking a slot, even when all slots are held, and it leaves `full` unchanged.
- R3: `full` is high exactly when every slot is held. While every slot is held and none is being freed in the current cycle, `wr_ready` is low for a write with a nonzero count.
- R4: `rel_done` is a one-cycle pulse. It is raised only once every write accepted before the release has reached a zero count. It is raised one cycle after the last such acknowledgement, or two cycles after the release is accepted if none is outstanding then.
- R5: A write accepted in the release's cycle or later does not delay `rel_done`.
- R6: While a release is pending, `rd_grant` follows `rd_req` and `wr_ready` is not lowered by the release.
- R7: An acquire (`sync_is_rel` = 0) is accepted while writes are still outstanding.
- R8: From the cycle after an acquire is accepted, `access_stall` is high, `rd_grant` is low and `wr_ready` is low. All three return to their unstalled values in the cycle after `acq_done` is seen.
- R9: `sync_ready` is low while an acquire or a release (`sync_is_rel` = 1) is pending, so no sync operation overtakes another.
- R10: An acknowledgement whose tag matches no held slot changes nothing.
- R11: After reset no slot is held, `full`, `access_stall` and `rel_done` are low, and `sync_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_valid | input | 1 | Write report valid |
| wr_ready | output | 1 | Write report can be taken |
| wr_tag | input | TAG_W | Tag of the reported write |
| wr_inv_cnt | input | CNT_W | Invalidation acknowledgements owed |
| ack_valid | input | 1 | Invalidation acknowledgement present |
| ack_tag | input | TAG_W | Tag of the acknowledged write |
| rd_req | input | 1 | Ordinary read wants to issue |
| rd_grant | output | 1 | Read may issue this cycle |
| sync_valid | input | 1 | Sync operation request valid |
| sync_is_rel | input | 1 | 1 for release, 0 for acquire |
| sync_ready | output | 1 | Sync request can be taken |
| acq_done | input | 1 | Memory reports the pending acquire complete |
| rel_done | output | 1 | One-cycle pulse: pending release complete |
| access_stall | output | 1 | Ordinary accesses held behind an acquire |
| full | output | 1 | Every tracker slot held |

## Verification
The slots are filled with mixed counts, and acknowledgements are then sent with unknown tags, with partial counts, and alongside a new write. These cases separate a decrement from a free, and a same-cycle slot reuse from a refusal. A release is issued while older writes are outstanding, and a younger write is added before the last older acknowledgement. This checks that `rel_done` depends only on the older writes and arrives on the predicted cycle. A second release is issued with nothing outstanding to check the two-cycle path. An acquire is issued over an outstanding write to show that earlier writes do not block it and that later reads and writes do wait for it.

// File: rtl/rcwt_pkg.sv
package rcwt_pkg;
  typedef enum logic {
    SYNC_ACQ = 1'b0,
    SYNC_REL = 1'b1
  } sync_kind_e;
endpackage

// File: rtl/rcwt_slot.sv
module rcwt_slot #(
  parameter int TAG_W = 4,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc_i,
  input  logic [TAG_W-1:0] tag_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             ack_valid_i,
  input  logic [TAG_W-1:0] ack_tag_i,
  input  logic             mark_i,
  output logic             vld_o,
  output logic             older_o,
  output logic             freeing_o
);
  logic             vld_q, older_q;
  logic [TAG_W-1:0] tag_q;
  logic [CNT_W-1:0] cnt_q;
  logic             hit;

  assign hit       = vld_q & ack_valid_i & (ack_tag_i == tag_q);
  assign freeing_o = hit & (cnt_q == CNT_W'(1));
  assign vld_o     = vld_q;
  assign older_o   = older_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q   <= 1'b0;
      older_q <= 1'b0;
      tag_q   <= '0;
      cnt_q   <= '0;
    end else if (alloc_i) begin
      vld_q   <= 1'b1;
      older_q <= 1'b0;
      tag_q   <= tag_i;
      cnt_q   <= cnt_i;
    end else begin
      if (hit) cnt_q <= cnt_q - CNT_W'(1);
      if (freeing_o) begin
        vld_q   <= 1'b0;
        older_q <= 1'b0;
      end else if (mark_i && vld_q) begin
        older_q <= 1'b1;
      end
    end
  end

  // R1: a held slot always still owes at least one acknowledgement
  assert_live_count_R1: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |-> (cnt_q != '0));
  // R3: allocation only lands on a free or freeing slot
  assert_alloc_free_slot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_i |-> (!vld_q || freeing_o));
endmodule

// File: rtl/rcwt_alloc.sv
module rcwt_alloc #(
  parameter int SLOTS = 4
) (
  input  logic [SLOTS-1:0] avail_i,
  output logic [SLOTS-1:0] grant_o,
  output logic             any_o
);
  always_comb begin
    grant_o = '0;
    for (int i = 0; i < SLOTS; i++) begin
      if (avail_i[i] && (grant_o == '0)) grant_o[i] = 1'b1;
    end
  end
  assign any_o = |avail_i;
endmodule

// File: rtl/rcwt_sync.sv
module rcwt_sync
  import rcwt_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sync_valid_i,
  input  logic sync_is_rel_i,
  input  logic acq_done_i,
  input  logic older_left_i,
  output logic sync_ready_o,
  output logic rel_fire_o,
  output logic acq_pend_o,
  output logic rel_done_o
);
  logic       acq_q, rel_q, done_q, fire;
  sync_kind_e kind;

  assign kind         = sync_kind_e'(sync_is_rel_i);
  assign sync_ready_o = ~acq_q & ~rel_q;
  assign fire         = sync_valid_i & sync_ready_o;
  assign rel_fire_o   = fire & (kind == SYNC_REL);
  assign acq_pend_o   = acq_q;
  assign rel_done_o   = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acq_q  <= 1'b0;
      rel_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= rel_q & ~older_left_i;
      if (fire && kind == SYNC_ACQ) acq_q <= 1'b1;
      else if (acq_done_i)          acq_q <= 1'b0;
      if (rel_fire_o)                  rel_q <= 1'b1;
      else if (rel_q && !older_left_i) rel_q <= 1'b0;
    end
  end

  // R9: never an acquire and a release in flight together
  assert_one_sync_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(acq_q && rel_q));
  // R4: completion is a single pulse that follows a pending release
  assert_rel_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  assert_rel_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> $past(rel_q));
endmodule

// File: rtl/rc_write_tracker.sv
module rc_write_tracker #(
  parameter int SLOTS = 4,
  parameter int TAG_W = 4,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic [CNT_W-1:0] wr_inv_cnt,
  input  logic             ack_valid,
  input  logic [TAG_W-1:0] ack_tag,
  input  logic             rd_req,
  output logic             rd_grant,
  input  logic             sync_valid,
  input  logic             sync_is_rel,
  output logic             sync_ready,
  input  logic             acq_done,
  output logic             rel_done,
  output logic             access_stall,
  output logic             full
);
  logic [SLOTS-1:0] vld, older, freeing, avail, grant, alloc;
  logic any_free, need_slot, wr_fire, acq_pend, rel_fire, older_left;

  assign avail     = ~vld | freeing;
  assign need_slot = (wr_inv_cnt != '0);
  assign wr_ready  = ~acq_pend & (~need_slot | any_free);
  assign wr_fire   = wr_valid & wr_ready;
  assign alloc     = grant & {SLOTS{wr_fire & need_slot}};
  assign older_left = |(older & ~freeing);
  assign rd_grant     = rd_req & ~acq_pend;
  assign access_stall = acq_pend;
  assign full         = &vld;

  rcwt_alloc #(.SLOTS(SLOTS)) u_alloc (
    .avail_i(avail), .grant_o(grant), .any_o(any_free)
  );

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    rcwt_slot #(.TAG_W(TAG_W), .CNT_W(CNT_W)) u_slot (
      .clk(clk), .rst_n(rst_n),
      .alloc_i(alloc[g]), .tag_i(wr_tag), .cnt_i(wr_inv_cnt),
      .ack_valid_i(ack_valid), .ack_tag_i(ack_tag),
      .mark_i(rel_fire),
      .vld_o(vld[g]), .older_o(older[g]), .freeing_o(freeing[g])
    );
  end

  rcwt_sync u_sync (
    .clk(clk), .rst_n(rst_n),
    .sync_valid_i(sync_valid), .sync_is_rel_i(sync_is_rel),
    .acq_done_i(acq_done), .older_left_i(older_left),
    .sync_ready_o(sync_ready), .rel_fire_o(rel_fire),
    .acq_pend_o(acq_pend), .rel_done_o(rel_done)
  );

  // R3: a write that needs a slot is only taken when one is available
  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && need_slot) |-> any_free);
  // R1: at most one slot is allocated per cycle
  assert_single_alloc_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(alloc));
  // R8: nothing ordinary issues behind a pending acquire
  assert_acq_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    access_stall |-> (!wr_fire && !rd_grant));
  // R2: a zero-count write leaves the set of held slots untouched
  assert_zero_no_slot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && !need_slot && !ack_valid) |=> (vld == $past(vld)));
endmodule

// File: tb/tb_rc_write_tracker.sv
module tb_rc_write_tracker;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_valid = 0, ack_valid = 0, rd_req = 0, sync_valid = 0, sync_is_rel = 0, acq_done = 0;
  logic [3:0] wr_tag = 0, wr_inv_cnt = 0, ack_tag = 0;
  logic wr_ready, rd_grant, sync_ready, rel_done, access_stall, full;

  int n_chk = 0, n_bad = 0, cyc = 0;
  int exp_q[$];
  bit finished = 0;

  always #2 clk = ~clk;  // 250 MHz
  always @(posedge clk) cyc <= cyc + 1;

  rc_write_tracker #(.SLOTS(4), .TAG_W(4), .CNT_W(4)) dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_tag(wr_tag), .wr_inv_cnt(wr_inv_cnt), .ack_valid(ack_valid),
    .ack_tag(ack_tag), .rd_req(rd_req), .rd_grant(rd_grant),
    .sync_valid(sync_valid), .sync_is_rel(sync_is_rel), .sync_ready(sync_ready),
    .acq_done(acq_done), .rel_done(rel_done), .access_stall(access_stall),
    .full(full)
  );

  task automatic check(input int act, input int exp, input string req);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // monitor: every completion pulse must match a predicted cycle
  always @(negedge clk) begin
    if (rst_n && rel_done && !finished) begin
      if (exp_q.size() == 0) check(cyc, -1, "R4 unexpected rel_done");
      else check(cyc, exp_q.pop_front(), "R4 rel_done cycle");
    end
  end

  task automatic idle();
    @(negedge clk);
    wr_valid = 0; ack_valid = 0; rd_req = 0; sync_valid = 0; acq_done = 0;
    #1;
  endtask

  task automatic drv(input bit wv, input int wt, input int wc,
                     input bit av, input int at);
    @(negedge clk);
    wr_valid = wv; wr_tag = 4'(wt); wr_inv_cnt = 4'(wc);
    ack_valid = av; ack_tag = 4'(at);
    rd_req = 0; sync_valid = 0; acq_done = 0;
    #1;
  endtask

  task automatic sync(input bit rel);
    @(negedge clk);
    wr_valid = 0; ack_valid = 0; rd_req = 0; acq_done = 0;
    sync_valid = 1; sync_is_rel = rel;
    #1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    // R11 reset state
    check(full, 0, "R11 full");
    check(sync_ready, 1, "R11 sync_ready");
    check(access_stall, 0, "R11 access_stall");
    check(rel_done, 0, "R11 rel_done");
    check(wr_ready, 1, "R11 wr_ready");

    // R1 fill all slots with nonzero counts
    drv(1, 1, 1, 0, 0);
    drv(1, 2, 2, 0, 0);
    drv(1, 3, 1, 0, 0);
    drv(1, 4, 3, 0, 0);
    drv(1, 7, 2, 0, 0);
    check(full, 1, "R3 full after four writes");
    check(wr_ready, 0, "R3 refused when full");
    drv(1, 8, 0, 0, 0);
    check(wr_ready, 1, "R2 zero-count write accepted when full");
    idle();
    check(full, 1, "R2 full unchanged");
    // R10 unknown tag
    drv(0, 0, 0, 1, 9);
    idle();
    check(full, 1, "R10 stray ack ignored");
    check(wr_ready, 1, "R10 idle ready (no write presented)");
    // R1 freeing slot reused in the same cycle
    drv(1, 5, 1, 1, 1);
    check(wr_ready, 1, "R1 freed slot usable same cycle");
    idle();
    check(full, 1, "R1 reused slot held");
    // R1 decrement without free
    drv(0, 0, 0, 1, 2);
    idle();
    check(full, 1, "R1 count 2->1 keeps slot");
    // release with tags 2,3,4,5 outstanding
    sync(1);
    check(sync_ready, 1, "R9 release accepted");
    @(negedge clk);
    sync_valid = 0; rd_req = 1; #1;
    check(rd_grant, 1, "R6 read passes pending release");
    check(sync_ready, 0, "R9 sync blocked by release");
    drv(0, 0, 0, 1, 2);
    drv(1, 6, 2, 0, 0);
    check(wr_ready, 1, "R6 write passes pending release");
    drv(0, 0, 0, 1, 3);
    drv(0, 0, 0, 1, 5);
    drv(0, 0, 0, 1, 4);
    drv(0, 0, 0, 1, 4);
    drv(0, 0, 0, 1, 4);
    exp_q.push_back(cyc + 1);  // R5 younger tag 6 ignored
    idle();
    check(rel_done, 1, "R4 rel_done pulse");
    idle();
    check(rel_done, 0, "R4 pulse one cycle");
    check(sync_ready, 1, "R9 free after release");
    // R7 acquire with tag 6 outstanding
    sync(0);
    check(sync_ready, 1, "R7 acquire accepted with writes outstanding");
    @(negedge clk);
    sync_valid = 0; rd_req = 1; wr_valid = 1; wr_tag = 10; wr_inv_cnt = 1; #1;
    check(access_stall, 1, "R8 stall");
    check(rd_grant, 0, "R8 read held");
    check(wr_ready, 0, "R8 write held");
    check(sync_ready, 0, "R9 sync blocked by acquire");
    @(negedge clk);
    wr_valid = 0; rd_req = 0; acq_done = 1; #1;
    @(negedge clk);
    acq_done = 0; rd_req = 1; #1;
    check(access_stall, 0, "R8 stall cleared");
    check(rd_grant, 1, "R8 read granted");
    // drain tag 6, then release with nothing older
    drv(0, 0, 0, 1, 6);
    drv(0, 0, 0, 1, 6);
    sync(1);
    exp_q.push_back(cyc + 2);
    idle();
    idle();
    check(rel_done, 1, "R4 empty release two cycles");
    idle();
    idle();
    check(exp_q.size(), 0, "R4 all completions seen");
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule